// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a single-channel SPI master. It takes one word at a time from a transmit FIFO, shifts it out on MOSI while an SCLK derived from the system clock toggles, and gathers MISO bits into a word that it hands to a receive FIFO. A select line frames each word. The FIFOs sit outside the block. The engine only sees an empty flag, the head word and a pop strobe on the transmit side, and a full flag, a push strobe and a data word on the receive side.

SCLK timing is not set by a single mode number. Four independent controls shape it:
- the idle level of SCLK;
- the SCLK direction (rising or falling) on which MISO is captured;
- the SCLK direction on which MOSI moves to its next bit;
- an optional lead delay before the first SCLK edge. Its length depends on the launch direction.

The select line has its own polarity control. The SCLK rate is the system clock divided by an even ratio. Word length (1 to 32) and bit order are programmable. The transmit and receive word lengths are set separately.

A state machine drives the engine. Its states are:
- IDLE: select inactive, SCLK at its idle level.
- LEAD: select active, waiting for the first edge.
- SHIFT: SCLK toggling.
- TRAIL: half a period after the last edge.

Its transitions are:
- IDLE→LEAD on start: enabled, transmit not empty, receive not full.
- LEAD→SHIFT on the tick that makes the first edge.
- SHIFT→TRAIL on the tick that makes the last edge.
- TRAIL→IDLE on the next tick, which pushes the received word.
- Any state→IDLE when enable is low.

Top module: `spi_shift_engine`

## Requirements
- R1: In IDLE, with `enable` high, `tx_empty` low and `rx_full` low, `tx_pop` is high for exactly one cycle. In the cycle after the pop, `sel` is at its active level.
- R2: While `enable` is low, `tx_empty` is high or `rx_full` is high, no word is started. `tx_pop` stays low, `sel` stays inactive and `sclk` stays at its idle level.
- R3: The half period H, in system cycles, is `clk_ratio` shifted right by one. Bit 0 of the ratio is ignored. Ratios below 4 act as 4. Successive SCLK edges within a word are exactly H cycles apart.
- R4: `sclk` rests at the level of `idle_high` when no word is in progress. It returns to that level after the final edge of a word.
- R5: The first SCLK edge comes L·H cycles after `sel` becomes active. L is 1 when `lead_delay` is 0. When `lead_delay` is 1, L is 3 if `launch_fall` is 0 and 2 if `launch_fall` is 1.
- R6: MISO is captured on rising SCLK edges when `cap_fall` is 0 and on falling edges when `cap_fall` is 1.
- R7: At every capture edge, `mosi` carries the next transmit bit. After a capture, MOSI moves on at the next edge whose direction matches `launch_fall` (0 = rising, 1 = falling). That edge may be the capture edge itself.
- R8: A word of N bits produces exactly 2N SCLK edges. N is `tx_len`, except that a value of 0 or above 32 gives N = 32.
- R9: A `bit_order` value of 1 sends and receives least-significant bit first. Any other value (0, 2, 3) gives most-significant bit first.
- R10: The received word holds the first M captured bits, where M = min(effective `rx_len`, N) and `rx_len` is clamped like `tx_len`. The bits are right-aligned and the upper bits are zero. With MSB-first order the first bit captured is bit M-1; with LSB-first order it is bit 0.
- R11: H cycles after the final edge, `sel` goes inactive and `rx_push` pulses for one cycle with `rx_data` valid. `sel` stays inactive for at least one cycle before the next word.
- R12: If `enable` goes low during a word, then in the next cycle `sel` is inactive and `sclk` is at its idle level, and that word is never pushed.
- R13: `sel` is driven to `sel_active_high` during a word and to its inverse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global run enable |
| clk_ratio | input | 8 | Even divider ratio, 4 to 254 |
| cap_fall | input | 1 | Capture on falling edges when 1 |
| idle_high | input | 1 | SCLK idle level |
| lead_delay | input | 1 | Adds the lead delay before the first edge |
| launch_fall | input | 1 | MOSI moves on falling edges when 1 |
| sel_active_high | input | 1 | Active level of the select line |
| tx_len | input | 6 | Transmit word length in bits |
| rx_len | input | 6 | Receive word length in bits |
| bit_order | input | 2 | 1 = LSB first, else MSB first |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Pops the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Pushes `rx_data` into the receive FIFO |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 1 | Frame select |

## Verification
The bench builds the engine with its default parameters: a 32-bit word, a 6-bit length field and an 8-bit ratio. With these values the full range of word lengths is reachable. That range includes a 1-bit word and the clamp values 0 and 40, alongside lengths of 8 and 13. The ratio is a run-time input, so the short ratios 2, 4, 5, 6 and 10 keep frames brief while still testing how odd and undersized ratios are rounded. A ratio of 254 makes a frame long enough to be cut off part way by dropping the enable.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } eng_state_t;

    // Per-word settings captured when a word starts
    typedef struct packed {
        logic cap_fall;
        logic launch_fall;
        logic lsb_first;
    } eng_mode_t;

endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               active,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    logic [RATIO_W-1:0] half_in;
    logic [RATIO_W-1:0] half_q;
    logic [RATIO_W-1:0] cnt_q;

    // ratio >> 1 drops bit 0; ratios below 4 run at the fastest legal rate
    assign half_in = (ratio < RATIO_W'(4)) ? RATIO_W'(2) : (ratio >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= RATIO_W'(2);
            cnt_q  <= '0;
        end else if (load) begin
            half_q <= half_in;
            cnt_q  <= half_in - RATIO_W'(1);
        end else if (active) begin
            if (cnt_q == '0) begin
                cnt_q <= half_q - RATIO_W'(1);
            end else begin
                cnt_q <= cnt_q - RATIO_W'(1);
            end
        end
    end

    assign tick = active && (cnt_q == '0);

endmodule

// File: rtl/spi_eng_fsm.sv
module spi_eng_fsm
    import spi_eng_pkg::*;
#(
    parameter int EDGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              tick,
    input  logic              idle_high,
    input  logic [1:0]        lead_len,
    input  logic [EDGE_W-1:0] n_edges,
    output logic              start,
    output logic              frame_on,
    output logic              edge_stb,
    output logic              edge_rise,
    output logic              sclk_lvl,
    output logic              rx_push
);
    eng_state_t        state_q, state_d;
    logic [1:0]        lead_q;
    logic [EDGE_W-1:0] edges_q;
    logic              sclk_q;
    logic              push_q;
    logic              lead_last;

    assign lead_last = (lead_q == 2'd1);
    assign start     = (state_q == ST_IDLE) && enable && !tx_empty && !rx_full;
    assign frame_on  = (state_q != ST_IDLE);
    assign edge_stb  = enable && tick &&
                       (((state_q == ST_LEAD) && lead_last) || (state_q == ST_SHIFT));
    assign edge_rise = !sclk_q;
    assign sclk_lvl  = sclk_q;
    assign rx_push   = push_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                              state_d = ST_LEAD;
            ST_LEAD:  if (tick && lead_last)                  state_d = ST_SHIFT;
            ST_SHIFT: if (tick && edges_q == EDGE_W'(1))      state_d = ST_TRAIL;
            ST_TRAIL: if (tick)                               state_d = ST_IDLE;
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
        end
    end

    // State register with its lead and edge counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lead_q  <= '0;
            edges_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                lead_q  <= lead_len;
                edges_q <= n_edges;
            end else begin
                if ((state_q == ST_LEAD) && tick) begin
                    lead_q <= lead_q - 2'd1;
                end
                if (edge_stb) begin
                    edges_q <= edges_q - EDGE_W'(1);
                end
            end
        end
    end

    // Registered outputs: serial clock level and push strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            push_q <= 1'b0;
        end else begin
            if (start) begin
                sclk_q <= idle_high;
            end else if (edge_stb) begin
                sclk_q <= ~sclk_q;
            end
            push_q <= enable && (state_q == ST_TRAIL) && tick;
        end
    end

endmodule

// File: rtl/spi_eng_txsr.sv
module spi_eng_txsr #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic [LEN_W-1:0]  n_bits,
    input  logic              lsb_in,
    input  logic              cap,
    input  logic              launch,
    output logic              mosi
);
    logic [DATA_W-1:0] sr_q;
    logic              lsb_q;
    logic              pend_q;
    logic              adv;

    // Advance only on a launch edge that follows (or coincides with) a capture
    assign adv = launch && (cap || pend_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            lsb_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (load) begin
            lsb_q  <= lsb_in;
            pend_q <= 1'b0;
            if (lsb_in) begin
                sr_q <= word;
            end else begin
                sr_q <= word << (DATA_W - int'(n_bits));
            end
        end else begin
            if (adv) begin
                sr_q   <= lsb_q ? (sr_q >> 1) : (sr_q << 1);
                pend_q <= 1'b0;
            end else if (cap) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign mosi = lsb_q ? sr_q[0] : sr_q[DATA_W-1];

endmodule

// File: rtl/spi_eng_rxsr.sv
module spi_eng_rxsr #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  n_keep,
    input  logic              lsb_first,
    input  logic              cap,
    input  logic              miso,
    output logic [DATA_W-1:0] word
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] w_q;
    logic [LEN_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            w_q   <= '0;
            cnt_q <= '0;
        end else if (cap && (cnt_q < n_keep)) begin
            if (lsb_first) begin
                w_q[cnt_q[IDX_W-1:0]] <= miso;
            end else begin
                w_q <= {w_q[DATA_W-2:0], miso};
            end
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign word = w_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 6,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [RATIO_W-1:0] clk_ratio,
    input  logic               cap_fall,
    input  logic               idle_high,
    input  logic               lead_delay,
    input  logic               launch_fall,
    input  logic               sel_active_high,
    input  logic [LEN_W-1:0]   tx_len,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic [1:0]         bit_order,
    input  logic               tx_empty,
    input  logic [DATA_W-1:0]  tx_data,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [DATA_W-1:0]  rx_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               sel
);
    localparam int EDGE_W = LEN_W + 1;

    function automatic logic [LEN_W-1:0] len_eff(input logic [LEN_W-1:0] l);
        if ((l == '0) || (int'(l) > DATA_W)) begin
            return LEN_W'(DATA_W);
        end
        return l;
    endfunction

    logic [LEN_W-1:0]  n_tx;
    logic [LEN_W-1:0]  n_rx_raw;
    logic [LEN_W-1:0]  n_rx;
    logic [1:0]        lead_len;
    logic              lsb_live;
    eng_mode_t         mode_q;
    logic [LEN_W-1:0]  keep_q;
    logic              start;
    logic              frame_on;
    logic              tick;
    logic              edge_stb;
    logic              edge_rise;
    logic              sclk_lvl;
    logic              cap;
    logic              launch;
    logic              mosi_sr;

    assign n_tx     = len_eff(tx_len);
    assign n_rx_raw = len_eff(rx_len);
    assign n_rx     = (n_rx_raw < n_tx) ? n_rx_raw : n_tx;
    assign lsb_live = (bit_order == 2'd1);
    assign lead_len = !lead_delay ? 2'd1 : (launch_fall ? 2'd2 : 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            keep_q <= '0;
        end else if (start) begin
            mode_q.cap_fall    <= cap_fall;
            mode_q.launch_fall <= launch_fall;
            mode_q.lsb_first   <= lsb_live;
            keep_q             <= n_rx;
        end
    end

    spi_eng_clkdiv #(.RATIO_W(RATIO_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .active (frame_on),
        .ratio  (clk_ratio),
        .tick   (tick)
    );

    spi_eng_fsm #(.EDGE_W(EDGE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .tick      (tick),
        .idle_high (idle_high),
        .lead_len  (lead_len),
        .n_edges   ({n_tx, 1'b0}),
        .start     (start),
        .frame_on  (frame_on),
        .edge_stb  (edge_stb),
        .edge_rise (edge_rise),
        .sclk_lvl  (sclk_lvl),
        .rx_push   (rx_push)
    );

    assign cap    = edge_stb && (edge_rise ^ mode_q.cap_fall);
    assign launch = edge_stb && (edge_rise ^ mode_q.launch_fall);

    spi_eng_txsr #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .word   (tx_data),
        .n_bits (n_tx),
        .lsb_in (lsb_live),
        .cap    (cap),
        .launch (launch),
        .mosi   (mosi_sr)
    );

    spi_eng_rxsr #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .n_keep    (keep_q),
        .lsb_first (mode_q.lsb_first),
        .cap       (cap),
        .miso      (miso),
        .word      (rx_data)
    );

    assign tx_pop = start;
    assign sclk   = frame_on ? sclk_lvl : idle_high;
    assign mosi   = frame_on && mosi_sr;
    assign sel    = frame_on ? sel_active_high : ~sel_active_high;

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_empty,
    input logic rx_full,
    input logic tx_pop,
    input logic rx_push,
    input logic sel,
    input logic sclk,
    input logic sel_active_high,
    input logic idle_high
);
    p_pop_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    p_pop_selects_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (sel == sel_active_high));

    p_no_pop_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full || tx_empty || !enable) |-> !tx_pop);

    p_push_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (sel != sel_active_high));

    p_push_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    p_abort_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((sel != sel_active_high) && !rx_push));

    p_abort_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sclk == idle_high));

endmodule

bind spi_shift_engine spi_eng_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .tx_empty        (tx_empty),
    .rx_full         (rx_full),
    .tx_pop          (tx_pop),
    .rx_push         (rx_push),
    .sel             (sel),
    .sclk            (sclk),
    .sel_active_high (sel_active_high),
    .idle_high       (idle_high)
);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  clk_ratio = 8'd4;
    logic        cap_fall = 1'b1, idle_high = 1'b0, lead_delay = 1'b1, launch_fall = 1'b0;
    logic        sel_active_high = 1'b0;
    logic [5:0]  tx_len = 6'd8, rx_len = 6'd8;
    logic [1:0]  bit_order = 2'd0;
    logic        tx_empty = 1'b1, rx_full = 1'b0, miso = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_pop, rx_push, sclk, mosi, sel;
    logic [31:0] rx_data;

    always #4 clk = ~clk;

    spi_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_ratio(clk_ratio),
        .cap_fall(cap_fall), .idle_high(idle_high), .lead_delay(lead_delay),
        .launch_fall(launch_fall), .sel_active_high(sel_active_high),
        .tx_len(tx_len), .rx_len(rx_len), .bit_order(bit_order),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .sel(sel)
    );

    int n_chk = 0, n_fail = 0, done_cnt = 0, abort_cnt = 0, cyc = 0, wd = 0;
    bit wd_hit = 1'b0, abort_ok = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] rx;
        logic [31:0] txb;
        logic [31:0] sl;
        int n;
        int lead;
        int h;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] txq[$];

    function automatic int eff(input logic [5:0] l);
        return (l == 0 || l > 32) ? 32 : int'(l);
    endfunction

    // Driver: builds the expected item from the current settings
    task automatic push_word(input logic [31:0] w, input logic [31:0] sl);
        exp_t e;
        int n, nr;
        bit msb;
        n   = eff(tx_len);
        nr  = (eff(rx_len) < n) ? eff(rx_len) : n;
        msb = (bit_order != 2'd1);
        e.rx = '0; e.txb = '0; e.sl = sl; e.n = n;
        for (int k = 0; k < n; k++) e.txb[k] = msb ? w[n-1-k] : w[k];
        for (int k = 0; k < nr; k++) begin
            if (msb) e.rx[nr-1-k] = sl[k];
            else     e.rx[k] = sl[k];
        end
        e.lead = !lead_delay ? 1 : (launch_fall ? 2 : 3);
        e.h    = (clk_ratio < 4) ? 2 : int'(clk_ratio >> 1);
        sb.push_back(e);
        txq.push_back(w);
    endtask

    // Transmit FIFO model
    bit pend = 1'b0;
    always begin
        @(negedge clk);
        if (pend) begin
            if (txq.size() == 0) chk(1'b0, "R1", "pop from empty", 0, 1);
            else void'(txq.pop_front());
        end
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 32'h0 : txq[0];
        #1;
        pend = tx_pop;
    end

    // Monitor / scoreboard
    bit   in_frame = 1'b0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    int   t0, tlast, edges, ci, txerr, sperr, leadv;
    exp_t cur;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!in_frame && (sel == sel_active_high)) begin
                if (sb.size() == 0) chk(1'b0, "R1", "frame without word", 0, 1);
                else begin
                    cur = sb[0]; in_frame = 1'b1; t0 = cyc; edges = 0;
                    ci = 0; txerr = 0; sperr = 0; leadv = -1;
                    miso = cur.sl[0];
                end
            end else if (in_frame && rx_push) begin
                chk(sel != sel_active_high, "R11", "select at push", 32'(sel), 32'(!sel_active_high));
                chk(rx_data === cur.rx, "R10", "received word", rx_data, cur.rx);
                chk(edges == 2 * cur.n, "R8", "edge count", 32'(edges), 32'(2 * cur.n));
                chk(txerr == 0, "R7", "mosi bits at capture", 32'(txerr), 0);
                chk(leadv == cur.lead * cur.h, "R5", "lead cycles", 32'(leadv), 32'(cur.lead * cur.h));
                chk(sperr == 0 && sclk == idle_high, "R3", "edge spacing", 32'(sperr), 0);
                void'(sb.pop_front());
                in_frame = 1'b0;
                done_cnt++;
            end else if (in_frame && (sel != sel_active_high)) begin
                chk(abort_ok, "R12", "frame ended without push", 0, 1);
                void'(sb.pop_front());
                in_frame = 1'b0;
                abort_cnt++;
            end else if (in_frame && (sclk != prev_sclk)) begin
                edges++;
                if (edges == 1) leadv = cyc - t0;
                else if (cyc - tlast != cur.h) sperr++;
                tlast = cyc;
                // R6: capture direction chosen by cap_fall
                if ((sclk == 1'b1) ^ cap_fall) begin
                    if (ci < cur.n && prev_mosi !== cur.txb[ci]) txerr++;
                    ci++;
                    miso = (ci < 32) ? cur.sl[ci] : 1'b0;
                end
            end else if (!in_frame && rx_push) begin
                chk(1'b0, "R11", "push outside frame", 1, 0);
            end
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            chk(1'b0, "R1", "watchdog expired", 32'(wd), 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_done(input int target);
        while (done_cnt < target && !wd_hit) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic quiet_check(input int cycles, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_pop || sel == sel_active_high || sclk != idle_high) ok = 1'b0;
        end
        chk(ok, req, "no start while held", 32'(ok), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 / R4 / R2: reset state
        chk(sel == 1'b1, "R13", "reset select level", 32'(sel), 1);
        chk(sclk == 1'b0, "R4", "reset sclk level", 32'(sclk), 0);
        chk(!tx_pop && !rx_push && !mosi, "R2", "reset strobes", 32'({tx_pop, rx_push, mosi}), 0);

        enable = 1'b1;
        // capture falling, idle low, delayed, launch rising, MSB first, 8 bits
        push_word(32'h0000_00A5, 32'h0000_00C3);
        wait_done(1);

        // R9: LSB first, 32 bits, capture rising, launch falling, no delay
        cap_fall = 0; idle_high = 0; lead_delay = 0; launch_fall = 1;
        clk_ratio = 8'd6; tx_len = 6'd32; rx_len = 6'd32; bit_order = 2'd1;
        push_word(32'h1234_5678, 32'hDEAD_BEEF);
        wait_done(2);

        // R3: odd ratio 5; 1-bit words back to back (R11 gap); idle high
        cap_fall = 0; idle_high = 1; lead_delay = 1; launch_fall = 1;
        clk_ratio = 8'd5; tx_len = 6'd1; rx_len = 6'd1; bit_order = 2'd0;
        push_word(32'h1, 32'h1);
        push_word(32'h0, 32'h0);
        wait_done(4);

        // R3: ratio 2 acts as 4; R10: rx shorter than tx; R9: order 2 is MSB; R13
        cap_fall = 1; idle_high = 1; lead_delay = 0; launch_fall = 0;
        clk_ratio = 8'd2; tx_len = 6'd13; rx_len = 6'd5; bit_order = 2'd2;
        sel_active_high = 1;
        push_word(32'hFFFF_A5C3, 32'h0000_0013);
        wait_done(5);

        // R8: length 0 and 40 both mean 32
        cap_fall = 1; idle_high = 0; lead_delay = 1; launch_fall = 0;
        clk_ratio = 8'd10; tx_len = 6'd0; rx_len = 6'd40; bit_order = 2'd0;
        sel_active_high = 0;
        push_word(32'h8000_0001, 32'h5555_AAAA);
        wait_done(6);

        // R2: receive FIFO full stalls the start
        tx_len = 6'd8; rx_len = 6'd8; clk_ratio = 8'd4;
        rx_full = 1;
        push_word(32'h0000_003C, 32'h0000_0081);
        quiet_check(40, "R2");
        rx_full = 0;
        wait_done(7);

        // R2: disabled engine does not start
        enable = 0;
        push_word(32'h0000_0096, 32'h0000_0069);
        quiet_check(30, "R2");
        enable = 1;
        wait_done(8);

        // R12: drop enable part way through a long word
        clk_ratio = 8'd254; tx_len = 6'd32; rx_len = 6'd32;
        abort_ok = 1;
        push_word(32'hCAFE_F00D, 32'h0F0F_0F0F);
        while (sel != sel_active_high && !wd_hit) @(negedge clk);
        repeat (300) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk(sel != sel_active_high && sclk == idle_high, "R12", "stopped next cycle",
            32'({sel, sclk}), 32'({!sel_active_high, idle_high}));
        quiet_check(50, "R12");
        chk(abort_cnt == 1 && done_cnt == 8, "R12", "aborted word not pushed",
            32'(done_cnt), 8);
        abort_ok = 0;
        enable = 1;
        // R1: nothing left to pop, so nothing starts
        quiet_check(20, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule